// File: doc/BRIEF.md
# Dual-Channel External Trigger Timestamp Capture

This block stamps asynchronous external events with the current value of a free-running 64-bit time counter. Each of two trigger inputs is brought into the clock domain through a short flop chain. The active edge on each input is chosen per channel. When that edge is seen, the counter value from that same cycle is stored in the channel's capture register.

Each capture can raise a per-channel event flag, subject to a per-channel enable. Software clears the flag by writing a one to it, which appears here as a one-cycle acknowledge pulse. The capture register is read as a high word and then a low word. A strobe on the high-word read freezes the low word that software sees, so a capture that lands between the two reads cannot produce a torn 64-bit value. The counter itself and the interrupt line belong to neighbouring blocks.

Top module: `etts_capture`

## Requirements
- R1: After reset, every capture word reads zero and every event flag is clear.
- R2: Suppose a trigger input changes just after clock edge n. The sampled counter value is then the one present between edges n+2 and n+3. It appears on the capture outputs, and the event flag sets, right after edge n+3 and not earlier.
- R3: Polarity bit 0 selects the rising edge and polarity bit 1 selects the falling edge. An edge of the other direction captures nothing.
- R4: A capture sets the channel's event flag only when that channel's event enable is 1. With the enable at 0, the capture register is still updated and the flag stays clear.
- R5: An acknowledge pulse clears the event flag on the following edge. If a capture happens in the same cycle, the flag stays set.
- R6: A new edge that arrives while the event flag is still set overwrites the capture register with the newer time.
- R7: While the timer enable is 0, edges change neither the capture register nor the event flag.
- R8: The two channels are independent. An edge, acknowledge or read strobe on one channel leaves the other channel's outputs unchanged.
- R9: A high-word read strobe freezes that channel's low-word output at its current value. The freeze lasts until a low-word read strobe, even if new captures arrive in between. The high-word output always shows the latest capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | N_CH | Asynchronous external trigger inputs |
| time_i | input | TW | Live time counter value |
| tmr_en_i | input | 1 | Timer enable; captures only while 1 |
| edge_pol_i | input | N_CH | Per-channel polarity: 0 rising, 1 falling |
| evt_en_i | input | N_CH | Per-channel event enable |
| ack_i | input | N_CH | Write-one-to-clear acknowledge pulses |
| rd_hi_i | input | N_CH | High-word read strobes |
| rd_lo_i | input | N_CH | Low-word read strobes |
| cap_hi_o | output | N_CH x TW/2 | Capture high words |
| cap_lo_o | output | N_CH x TW/2 | Capture low words (frozen between reads) |
| evt_o | output | N_CH | Capture event flags |

## Verification
The time input advances every cycle. This lets a captured value pin down the exact detection cycle and so separate the correct synchroniser depth from one stage too many or too few. Rising and falling edges are each driven under both polarity settings, so an inverted polarity bit fails in either direction. Acknowledge is tested both alone and in the same cycle as a capture, which separates set-priority from clear-priority. A capture placed between the high and low reads, with low words that differ, shows whether the low word is really frozen.

// File: rtl/etts_pkg.sv
package etts_pkg;
  localparam int N_CH_DEF    = 2;
  localparam int TW_DEF      = 64;
  localparam int SYNC_DEF    = 2;
endpackage

// File: rtl/etts_edge_sync.sv
module etts_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic pol_i,
  output logic edge_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], trig_i};
  end

  logic rise, fall;
  assign rise   =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall   = ~sh_q[STAGES-1] &  sh_q[STAGES];
  assign edge_o = pol_i ? fall : rise;

  AST_EDGE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> !edge_o); // R3
endmodule

// File: rtl/etts_chan.sv
module etts_chan #(
  parameter int TW = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            edge_i,
  input  logic            en_i,
  input  logic            mask_i,
  input  logic            ack_i,
  input  logic            rd_hi_i,
  input  logic            rd_lo_i,
  input  logic [TW-1:0]   time_i,
  output logic [TW/2-1:0] hi_o,
  output logic [TW/2-1:0] lo_o,
  output logic            evt_o
);
  localparam int HW = TW / 2;

  logic [TW-1:0] cap_q;
  logic [HW-1:0] lo_shadow_q;
  logic          lock_q, evt_q, fire;

  assign fire = edge_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cap_q <= '0;
    else if (fire) cap_q <= time_i;
  end

  // set has priority over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               evt_q <= 1'b0;
    else if (fire && mask_i)   evt_q <= 1'b1;
    else if (ack_i)            evt_q <= 1'b0;
  end

  // freeze low word between high and low reads
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q      <= 1'b0;
      lo_shadow_q <= '0;
    end else if (rd_hi_i) begin
      lock_q      <= 1'b1;
      lo_shadow_q <= cap_q[HW-1:0];
    end else if (rd_lo_i) begin
      lock_q      <= 1'b0;
    end
  end

  assign hi_o  = cap_q[TW-1:HW];
  assign lo_o  = lock_q ? lo_shadow_q : cap_q[HW-1:0];
  assign evt_o = evt_q;

  AST_EVT_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> $past(edge_i && en_i && mask_i)); // R4
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !(edge_i && en_i)) |=> !evt_o); // R5
  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(hi_o)); // R7
  AST_LO_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !rd_hi_i && !rd_lo_i) |=> $stable(lo_o)); // R9
endmodule

// File: rtl/etts_capture.sv
module etts_capture
  import etts_pkg::*;
#(
  parameter int N_CH   = N_CH_DEF,
  parameter int TW     = TW_DEF,
  parameter int STAGES = SYNC_DEF
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_CH-1:0]           trig_i,
  input  logic [TW-1:0]             time_i,
  input  logic                      tmr_en_i,
  input  logic [N_CH-1:0]           edge_pol_i,
  input  logic [N_CH-1:0]           evt_en_i,
  input  logic [N_CH-1:0]           ack_i,
  input  logic [N_CH-1:0]           rd_hi_i,
  input  logic [N_CH-1:0]           rd_lo_i,
  output logic [N_CH-1:0][TW/2-1:0] cap_hi_o,
  output logic [N_CH-1:0][TW/2-1:0] cap_lo_o,
  output logic [N_CH-1:0]           evt_o
);
  logic [N_CH-1:0] edge_det;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    etts_edge_sync #(.STAGES(STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (trig_i[c]),
      .pol_i  (edge_pol_i[c]),
      .edge_o (edge_det[c])
    );
    etts_chan #(.TW(TW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .edge_i  (edge_det[c]),
      .en_i    (tmr_en_i),
      .mask_i  (evt_en_i[c]),
      .ack_i   (ack_i[c]),
      .rd_hi_i (rd_hi_i[c]),
      .rd_lo_i (rd_lo_i[c]),
      .time_i  (time_i),
      .hi_o    (cap_hi_o[c]),
      .lo_o    (cap_lo_o[c]),
      .evt_o   (evt_o[c])
    );
  end
endmodule

// File: tb/tb_etts_capture.sv
module tb_etts_capture;
  localparam int N_CH = 2;
  localparam int TW   = 64;

  logic clk = 0, rst_ni = 0;
  logic [N_CH-1:0] trig = '0, pol = '0, ena = '0, ack = '0, rdh = '0, rdl = '0;
  logic tmr_en = 0;
  logic [TW-1:0] tcnt = '0, base = 64'h0000_00A5_FFFF_FFF0;
  logic [TW-1:0] time_v;
  logic [N_CH-1:0][31:0] hi, lo;
  logic [N_CH-1:0] evt;
  int n_run = 0, n_fail = 0;

  assign time_v = base + tcnt;

  always #2.5 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1;

  etts_capture dut (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig), .time_i(time_v),
    .tmr_en_i(tmr_en), .edge_pol_i(pol), .evt_en_i(ena), .ack_i(ack),
    .rd_hi_i(rdh), .rd_lo_i(rdl), .cap_hi_o(hi), .cap_lo_o(lo), .evt_o(evt)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // toggle trigger c to level v at a negedge; return expected capture time
  task automatic fire(int c, logic v, output logic [63:0] exp_t);
    @(negedge clk);
    trig[c] = v;
    exp_t = base + tcnt + 2;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] cap(int c);
    return {hi[c], lo[c]};
  endfunction

  task automatic t_reset();
    chk("R1 cap0", cap(0), 0);
    chk("R1 cap1", cap(1), 0);
    chk("R1 evt", {62'd0, evt}, 0);
  endtask

  task automatic t_latency();
    logic [63:0] e;
    @(negedge clk);
    trig[0] = 1;
    e = base + tcnt + 2;
    repeat (2) @(negedge clk);
    chk("R2 no early evt", {63'd0, evt[0]}, 0);
    @(negedge clk);
    chk("R2 evt set", {63'd0, evt[0]}, 1);
    chk("R2 capture value", cap(0), e);
    chk("R8 ch1 untouched", cap(1), 0);
  endtask

  task automatic ack_pulse(int c);
    @(negedge clk); ack[c] = 1;
    @(negedge clk); ack[c] = 0;
  endtask

  task automatic t_ack();
    ack_pulse(0);
    chk("R5 ack clears", {63'd0, evt[0]}, 0);
  endtask

  task automatic t_polarity();
    logic [63:0] e, keep;
    keep = cap(0);
    fire(0, 0, e); // falling edge, rising polarity
    chk("R3 falling ignored", cap(0), keep);
    chk("R3 no evt", {63'd0, evt[0]}, 0);
    pol[0] = 1;
    fire(0, 1, e); // rising, falling polarity
    chk("R3 rising ignored", cap(0), keep);
    fire(0, 0, e);
    chk("R3 falling captured", cap(0), e);
    chk("R3 falling evt", {63'd0, evt[0]}, 1);
    ack_pulse(0);
    pol[0] = 0;
  endtask

  task automatic t_overwrite();
    logic [63:0] e1, e2;
    fire(1, 1, e1);
    chk("R6 first", cap(1), e1);
    fire(1, 0, e2);
    fire(1, 1, e2);
    chk("R6 overwritten", cap(1), e2);
    chk("R6 evt still set", {63'd0, evt[1]}, 1);
  endtask

  task automatic t_ack_collide();
    logic [63:0] e;
    fire(1, 0, e);
    @(negedge clk);
    trig[1] = 1;
    e = base + tcnt + 2;
    repeat (2) @(negedge clk);
    ack[1] = 1; // active on the capture edge
    @(negedge clk);
    ack[1] = 0;
    chk("R5 capture beats ack", {63'd0, evt[1]}, 1);
    chk("R5 value", cap(1), e);
    ack_pulse(1);
    chk("R5 later ack clears", {63'd0, evt[1]}, 0);
  endtask

  task automatic t_mask();
    logic [63:0] e;
    ena[0] = 0;
    fire(0, 0, e);
    fire(0, 1, e);
    chk("R4 stored while masked", cap(0), e);
    chk("R4 no evt masked", {63'd0, evt[0]}, 0);
    ena[0] = 1;
  endtask

  task automatic t_disabled();
    logic [63:0] e, k0, k1;
    fire(0, 0, e);
    fire(1, 0, e);
    k0 = cap(0); k1 = cap(1);
    tmr_en = 0;
    fire(0, 1, e);
    fire(1, 1, e);
    chk("R7 ch0 held", cap(0), k0);
    chk("R7 ch1 held", cap(1), k1);
    chk("R7 no evt", {62'd0, evt}, 0);
    tmr_en = 1;
  endtask

  task automatic t_coherent();
    logic [63:0] a, b;
    logic [31:0] lo1;
    base = 64'h0000_0007_FFFF_FF00;
    fire(0, 0, a);
    fire(0, 1, a);
    lo1 = lo[1];
    @(negedge clk); rdh[0] = 1;
    @(negedge clk); rdh[0] = 0;
    fire(0, 0, b);
    fire(0, 1, b);
    chk("R9 hi live", {32'd0, hi[0]}, {32'd0, b[63:32]});
    chk("R9 lo frozen", {32'd0, lo[0]}, {32'd0, a[31:0]});
    chk("R8 ch1 lo unaffected", {32'd0, lo[1]}, {32'd0, lo1});
    @(negedge clk); rdl[0] = 1;
    @(negedge clk); rdl[0] = 0;
    chk("R9 lo released", {32'd0, lo[0]}, {32'd0, b[31:0]});
    ack_pulse(0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    tmr_en = 1;
    ena = '1;
    repeat (2) @(negedge clk);
    t_reset();
    t_latency();
    t_ack();
    t_polarity();
    t_overwrite();
    t_ack_collide();
    t_mask();
    t_disabled();
    t_coherent();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule